// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

The block is a timer running in split mode: two independent 8-bit up-counters, a low half and a high half. Each half has its own reload register. On the count step where a half passes 0xFF, its counter is loaded from that reload register and its sticky overflow flag is set.

Each half selects its own count enable. The choices are every system clock cycle, one pulse per 12 system clocks, one pulse per 8 rising edges of an asynchronous real-time clock input, or one pulse per rising edge of an asynchronous comparator input. The two async inputs are synchronized and edge-detected inside the block, so the whole block runs on the system clock alone. The low half counts whenever split mode is on. The high half also needs its run bit.

Software reaches the control byte, the flags, both reload registers and both counters through a simple single-cycle write port and a combinational read port. The interrupt output is a level: the OR of the overflow flags that are enabled.

Top module: `split_reload_timer`

## Requirements
- R1: After reset, every register (control, flags, both reloads, both counters) reads 0 and irq_o is low.
- R2: Register addresses are 0 control, 1 flags (bit0 low, bit1 high), 2 low reload, 3 high reload, 4 low counter and 5 high counter. A write with we_i high takes effect at the clock edge. rdata_o shows the addressed register combinationally, and unused addresses read 0.
- R3: The control bits are: bit0 split enable, bit1 high run, bit2 high sysclk mode, bit3 low sysclk mode, bits5:4 shared source select, bit6 interrupt enable and bit7 low-interrupt enable. The low half counts whenever bit0 is 1. The high half counts only when bit0 and bit1 are both 1. Neither half counts when bit0 is 0.
- R4: When a half's sysclk mode bit is 1, that half advances by one on every system clock edge.
- R5: A count step at 0xFF loads the half's reload value and sets that half's flag on the same edge.
- R6: When the mode bit is 0 and the source select is 00, the half advances once per 12 system clocks, from a free-running prescaler.
- R7: When the mode bit is 0 and the source select is 01, the half advances once per 8 synchronized rising edges of rtc_i.
- R8: When the mode bit is 0 and the source select is 11, the half advances once per synchronized rising edge of cmp_i.
- R9: When the mode bit is 0 and the source select is 10 (reserved), the half does not count.
- R10: Hardware never clears a flag. A write to address 1 loads both flags, and an overflow on the same edge keeps its flag set.
- R11: irq_o is high whenever the interrupt enable is 1 and the high flag is set.
- R12: The low flag drives irq_o only when both the interrupt enable and the low-interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| rtc_i | input | 1 | Asynchronous real-time clock input |
| cmp_i | input | 1 | Asynchronous comparator output |
| irq_o | output | 1 | Level interrupt request |

## Verification
A vector table drives each half in sysclk mode from different start and reload values and step counts. These cover runs that never reach 0xFF, a single wrap, several wraps, and a reload of 0xFF. Each run separates plain incrementing from correct reload and flag setting. Directed runs then feed each slow source in turn: a 120-cycle window for the divide-by-12 path, 16 real-time clock edges, 5 comparator edges, and the reserved code. Each must give an exact count, which tells the sources apart. Further directed runs hold the high half with its run bit off while the low half moves. The interrupt tests toggle the two enable bits against each flag, which separates the high-flag path from the gated low-flag path and shows that flags stay set.

// File: rtl/split_tmr_pkg.sv
package split_tmr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;

  typedef enum logic [1:0] {
    SRC_DIV_SYS = 2'b00,
    SRC_RTC     = 2'b01,
    SRC_RSVD    = 2'b10,
    SRC_CMP     = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic     lo_irq_en;
    logic     irq_en;
    src_sel_e ext_sel;
    logic     mode_lo;
    logic     mode_hi;
    logic     run_hi;
    logic     split;
  } ctrl_t;
endpackage

// File: rtl/split_tmr_edge_sync.sv
module split_tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/split_tmr_ticks.sv
module split_tmr_ticks #(
  parameter int unsigned DIV_SYS     = 12,
  parameter int unsigned DIV_RTC     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rtc_i,
  input  logic cmp_i,
  output logic sys_tick_o,
  output logic rtc_tick_o,
  output logic cmp_tick_o
);
  localparam int unsigned SW = (DIV_SYS > 1) ? $clog2(DIV_SYS) : 1;
  localparam int unsigned RW = (DIV_RTC > 1) ? $clog2(DIV_RTC) : 1;
  localparam logic [SW-1:0] SYS_LAST = SW'(DIV_SYS - 1);
  localparam logic [RW-1:0] RTC_LAST = RW'(DIV_RTC - 1);

  logic [SW-1:0] sys_q;
  logic [RW-1:0] rtc_q;
  logic          rtc_rise;

  split_tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
    .clk_i, .rst_ni, .async_i(rtc_i), .rise_o(rtc_rise)
  );
  split_tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk_i, .rst_ni, .async_i(cmp_i), .rise_o(cmp_tick_o)
  );

  // free-running prescalers, enable pulses only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sys_q <= '0;
    else if (sys_q == SYS_LAST) sys_q <= '0;
    else                       sys_q <= sys_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rtc_q <= '0;
    else if (rtc_rise) begin
      if (rtc_q == RTC_LAST) rtc_q <= '0;
      else                   rtc_q <= rtc_q + 1'b1;
    end
  end

  assign sys_tick_o = (sys_q == SYS_LAST);
  assign rtc_tick_o = rtc_rise && (rtc_q == RTC_LAST);
endmodule

// File: rtl/split_tmr_half.sv
module split_tmr_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_we_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, rld_q;

  assign wrap_o = step_i && !cnt_we_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_we_i) rld_q <= wdata_i;
  end

  // software write wins over a count step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (wrap_o)   cnt_q <= rld_q;
    else if (step_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import split_tmr_pkg::*;
#(
  parameter int unsigned DIV_SYS     = 12,
  parameter int unsigned DIV_RTC     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rtc_i,
  input  logic              cmp_i,
  output logic              irq_o
);
  ctrl_t                  ctrl_q;
  logic [1:0]             flags_q;
  logic [1:0][DATA_W-1:0] cnt_q;
  logic [1:0][DATA_W-1:0] reload_q;
  logic [1:0]             cnt_en;
  logic [1:0]             wrap;
  logic [1:0]             mode_sys;
  logic [1:0]             run;
  logic                   sys_tick, rtc_tick, cmp_tick;

  split_tmr_ticks #(
    .DIV_SYS(DIV_SYS), .DIV_RTC(DIV_RTC), .SYNC_STAGES(SYNC_STAGES)
  ) u_ticks (
    .clk_i, .rst_ni, .rtc_i, .cmp_i,
    .sys_tick_o(sys_tick), .rtc_tick_o(rtc_tick), .cmp_tick_o(cmp_tick)
  );

  assign mode_sys = {ctrl_q.mode_hi, ctrl_q.mode_lo};
  assign run      = {ctrl_q.split & ctrl_q.run_hi, ctrl_q.split};

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] RA = A_RLD_LO + ADDR_W'(h);
    localparam logic [ADDR_W-1:0] CA = A_CNT_LO + ADDR_W'(h);
    logic src;

    always_comb begin
      if (mode_sys[h]) src = 1'b1;
      else begin
        unique case (ctrl_q.ext_sel)
          SRC_DIV_SYS: src = sys_tick;
          SRC_RTC:     src = rtc_tick;
          SRC_CMP:     src = cmp_tick;
          default:     src = 1'b0;
        endcase
      end
    end

    assign cnt_en[h] = src & run[h];

    split_tmr_half #(.W(DATA_W)) u_half (
      .clk_i, .rst_ni,
      .cnt_we_i(we_i && (addr_i == CA)),
      .rld_we_i(we_i && (addr_i == RA)),
      .wdata_i,
      .step_i(cnt_en[h]),
      .cnt_o(cnt_q[h]),
      .rld_o(reload_q[h]),
      .wrap_o(wrap[h])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL)   ctrl_q <= ctrl_t'(wdata_i);
  end

  // an overflow on the write edge keeps its flag set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flags_q <= '0;
    else if (we_i && addr_i == A_FLAGS)  flags_q <= wdata_i[1:0] | wrap;
    else                                 flags_q <= flags_q | wrap;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:         rdata_o = ctrl_q;
      A_FLAGS:        rdata_o = {{(DATA_W-2){1'b0}}, flags_q};
      A_RLD_LO:       rdata_o = reload_q[0];
      A_RLD_LO + 3'd1: rdata_o = reload_q[1];
      A_CNT_LO:       rdata_o = cnt_q[0];
      A_CNT_LO + 3'd1: rdata_o = cnt_q[1];
      default:        rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.irq_en & (flags_q[1] | (ctrl_q.lo_irq_en & flags_q[0]));
endmodule

// File: rtl/split_reload_timer_chk.sv
module split_reload_timer_chk
  import split_tmr_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   we_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   irq_o,
  input logic [7:0]             ctrl_i,
  input logic [1:0]             flags_i,
  input logic [1:0][DATA_W-1:0] cnt_i,
  input logic [1:0][DATA_W-1:0] rld_i,
  input logic [1:0]             cnt_en_i
);
  logic wr_flags, wr_cnt_lo, wr_cnt_hi;
  assign wr_flags  = we_i && addr_i == A_FLAGS;
  assign wr_cnt_lo = we_i && addr_i == A_CNT_LO;
  assign wr_cnt_hi = we_i && addr_i == A_CNT_LO + 3'd1;

  a_r3_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ctrl_i[0] && ctrl_i[1]) && !wr_cnt_hi) |=> $stable(cnt_i[1]));

  a_r5_lo_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i[0] && cnt_i[0] == '1 && !wr_cnt_lo)
      |=> (flags_i[0] && cnt_i[0] == $past(rld_i[0])));

  a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[5:4] == 2'b10 && !ctrl_i[3] && !wr_cnt_lo) |=> $stable(cnt_i[0]));

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[1] && !wr_flags) |=> flags_i[1]);

  a_r11_irq_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && flags_i[1]) |-> irq_o);

  a_r12_lo_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && !flags_i[1]) |-> !irq_o);
endmodule

bind split_reload_timer split_reload_timer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .irq_o(irq_o),
  .ctrl_i(ctrl_q), .flags_i(flags_q), .cnt_i(cnt_q), .rld_i(reload_q),
  .cnt_en_i(cnt_en)
);

// File: tb/split_reload_timer_tb.sv
`timescale 1ns/1ps
module split_reload_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rtc = 1'b0, cmp = 1'b0;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  split_reload_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rtc_i(rtc), .cmp_i(cmp), .irq_o(irq)
  );

  // {hi_half, start, reload, steps}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h00, 8'd10},
    {1'b0, 8'hFE, 8'h40, 8'd3},
    {1'b0, 8'hF0, 8'hF0, 8'd40},
    {1'b1, 8'h10, 8'h00, 8'd5},
    {1'b1, 8'hFF, 8'h80, 8'd1},
    {1'b1, 8'hFD, 8'hFE, 8'd10},
    {1'b0, 8'hFF, 8'hFF, 8'd4},
    {1'b1, 8'h00, 8'h00, 8'd255}
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig, input int n);
    for (int i = 0; i < n; i++) begin
      sig = 1'b1; idle(3); sig = 1'b0; idle(3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, ec, er;
    logic       ef;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd4, v); chk("R1 cnt_lo", v, 8'h00);
    rd(3'd1, v); chk("R1 flags", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 register access
    wr(3'd3, 8'h5A); rd(3'd3, v); chk("R2 rld_hi readback", v, 8'h5A);
    rd(3'd7, v); chk("R2 unused addr", v, 8'h00);

    // R4 R5 vector table, sysclk mode
    foreach (VEC[i]) begin
      wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      wr(VEC[i][24] ? 3'd3 : 3'd2, VEC[i][15:8]);
      wr(VEC[i][24] ? 3'd5 : 3'd4, VEC[i][23:16]);
      wr(3'd0, VEC[i][24] ? 8'h07 : 8'h09);
      ec = VEC[i][23:16]; er = VEC[i][15:8]; ef = 1'b0;
      for (int s = 0; s < int'(VEC[i][7:0]); s++) begin
        if (ec == 8'hFF) begin ec = er; ef = 1'b1; end
        else ec = ec + 8'd1;
      end
      idle(int'(VEC[i][7:0]));
      rd(VEC[i][24] ? 3'd5 : 3'd4, v); chk($sformatf("R4 R5 vec%0d cnt", i), v, ec);
      rd(3'd1, v); chk($sformatf("R5 vec%0d flag", i), {7'b0, v[VEC[i][24]]}, {7'b0, ef});
    end

    // R3 high half held without run bit, low half runs
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd0, 8'h0D); idle(20);
    rd(3'd4, v); chk("R3 lo counts", v, 8'd20);
    rd(3'd5, v); chk("R3 hi held", v, 8'd0);
    wr(3'd0, 8'h0C); wr(3'd4, 8'h00); idle(10);
    rd(3'd4, v); chk("R3 split off", v, 8'd0);

    // R6 div-by-12 source
    wr(3'd4, 8'h00); wr(3'd0, 8'h01); idle(120);
    rd(3'd4, v); chk("R6 div12", v, 8'd10);

    // R9 reserved source
    wr(3'd0, 8'h00); wr(3'd4, 8'h33); wr(3'd0, 8'h21); idle(60);
    rd(3'd4, v); chk("R9 reserved", v, 8'h33);

    // R7 rtc divided by 8
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h11);
    pulse(rtc, 16); idle(5);
    rd(3'd4, v); chk("R7 rtc div8", v, 8'd2);

    // R8 comparator edges
    wr(3'd0, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'h31);
    pulse(cmp, 5); idle(5);
    rd(3'd4, v); chk("R8 cmp edges", v, 8'd5);

    // R10 R12 low-flag interrupt gating
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'hFE);
    wr(3'd0, 8'h4D); idle(4);
    rd(3'd1, v); chk("R12 lo flag set", v, 8'h01);
    chk("R12 irq gated off", {7'b0, irq}, 8'h00);
    idle(30);
    rd(3'd1, v); chk("R10 flag sticky", v, 8'h01);
    wr(3'd0, 8'hCD); #1;
    chk("R12 irq from lo", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'hC0); wr(3'd1, 8'h00); #1;
    chk("R10 clear by write", {7'b0, irq}, 8'h00);

    // R11 high-flag interrupt
    wr(3'd3, 8'h00); wr(3'd5, 8'hFF); wr(3'd0, 8'h47); idle(2);
    rd(3'd1, v); chk("R11 hi flag", {7'b0, v[1]}, 8'h01);
    chk("R11 irq hi", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h07); #1;
    chk("R11 irq disabled", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule